// File: doc/BRIEF.md
# GPU First-Level Data Cache Access Controller

This block decides, in the same cycle a request is presented, whether a first-level data cache in a many-threaded core can take the request. It reports HIT, MISS or RESERVATION_FAIL. It keeps a set-associative tag array with a four-valued state per line (empty, reserved for a pending fetch, clean, dirty). It keeps a small table of outstanding line fetches that several reads to the same line can share. It also owns a bounded first-in first-out queue of requests bound for the next memory level. Data storage, coherence between cores and the next memory level are outside the block.

Each request carries a kind code. The kind decides how the request is handled:
- A global write that hits flushes the line: a full-line writeback is queued and the line is dropped.
- A local write that hits marks the line dirty, so it is written back later on eviction.
- A write that misses goes straight to the queue and does not claim a line.
- A read miss either shares an outstanding fetch or claims a victim line and queues a full-line fetch. If the victim was dirty, a writeback is queued behind the fetch.

When a fill arrives, the reserved line becomes clean. The reads that waited on that line are then handed back one per cycle, each with its original address and size.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is empty, the outgoing queue is empty (`mq_valid`=0) and no waiting read is handed back (`rel_valid`=0).
- R2: `resp_status` is combinational and valid while `req_valid`=1, with codes 0=HIT, 1=MISS, 2=RESERVATION_FAIL; `req_kind` uses 0=read, 1=local write, 2=global write. A read that hits a clean or dirty line returns HIT and queues nothing. A read miss that starts a new fetch returns MISS and queues a fetch (`mq_kind`=0) for the line-aligned address with size equal to the line size.
- R3: A global write that hits returns HIT, queues a full-line writeback (`mq_kind`=2) for that line's aligned address and makes the line empty, so a later read to it misses. If the queue is already full, it returns RESERVATION_FAIL and the line is left intact.
- R4: A local write that hits returns HIT and marks the line dirty. When a dirty line is later evicted, a writeback is queued for it.
- R5: A write that misses returns MISS and queues a write-through (`mq_kind`=1) with its own address and size, without claiming a line. If the queue is full, it returns RESERVATION_FAIL.
- R6: A read miss returns RESERVATION_FAIL whenever the queue occupancy plus one is not below the queue depth.
- R7: A read miss to a line with an outstanding fetch that has merged fewer than MERGE_MAX requests returns MISS and queues nothing. Once MERGE_MAX requests have been merged, a further read to that line returns RESERVATION_FAIL.
- R8: A read miss with no outstanding fetch returns RESERVATION_FAIL when every fetch-tracking entry is busy, or when every way of the set is reserved.
- R9: The victim is the lowest-numbered empty way of the set. If there is none, it is the least recently used way that is not reserved. A dirty victim makes the controller queue a full-line writeback to the victim's address directly after the fetch.
- R10: A fill for a line with an outstanding fetch makes that line clean, so later reads hit. Starting the cycle after the fill, the merged reads are handed back on `rel_*`, one per cycle, in arrival order, with their original address and size.
- R11: The outgoing queue is first-in first-out, never holds more than MQ_DEPTH entries, and removes its head when `mq_valid` and `mq_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 local write, 2 global write |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | SIZE_W | Request size in bytes |
| resp_status | output | 2 | 0 HIT, 1 MISS, 2 RESERVATION_FAIL |
| mq_valid | output | 1 | Outgoing queue head valid |
| mq_ready | input | 1 | Next level takes the head |
| mq_kind | output | 2 | 0 line fetch, 1 write-through, 2 writeback |
| mq_addr | output | ADDR_W | Head address |
| mq_size | output | SIZE_W | Head size in bytes |
| fill_valid | input | 1 | Line data returned from below |
| fill_addr | input | ADDR_W | Address within the filled line |
| rel_valid | output | 1 | A waiting read is handed back |
| rel_addr | output | ADDR_W | Original address of that read |
| rel_size | output | SIZE_W | Original size of that read |

## Verification
The assertions check the following on every cycle:
- The queue never overflows.
- A two-entry push happens only with two slots free.
- A refused request never grows the queue.
- A non-merging miss always grows the queue.
- No merge counter passes its limit.
- No tag matches two live ways.
- A fill of a tracked line is always followed by a hand-back.

Only the directed scenarios can show the rest: the exact addresses, sizes and kinds of queued traffic, the victim order and the dirty writeback, that an invalidated or write-missed line really misses afterwards, and the order of the handed-back reads.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {ST_EMPTY, ST_RSV, ST_CLEAN, ST_DIRTY} line_st_t;

  localparam logic [1:0] RES_HIT  = 2'd0;
  localparam logic [1:0] RES_MISS = 2'd1;
  localparam logic [1:0] RES_FAIL = 2'd2;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_LW = 2'd1;
  localparam logic [1:0] ACC_GW = 2'd2;

  localparam logic [1:0] MQ_FETCH = 2'd0;
  localparam logic [1:0] MQ_WT    = 2'd1;
  localparam logic [1:0] MQ_WB    = 2'd2;
endpackage

// File: rtl/dcache_tags.sv
module dcache_tags
  import dcache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             vic_ok,
  output logic [WAY_W-1:0] vic_way,
  output line_st_t         vic_st,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  input  line_st_t         upd_st,
  input  logic             upd_tag,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way
);
  line_st_t         st_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  match;

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = (st_q[lk_set][w] == ST_CLEAN || st_q[lk_set][w] == ST_DIRTY) &&
                 (tag_q[lk_set][w] == lk_tag);
      if (match[w]) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // Empty way first (lowest index); else oldest way not reserved.
  always_comb begin
    logic found_empty;
    logic [WAY_W-1:0] best_age;
    found_empty = 1'b0;
    best_age = '0;
    vic_ok = 1'b0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found_empty && st_q[lk_set][w] == ST_EMPTY) begin
        found_empty = 1'b1;
        vic_ok = 1'b1;
        vic_way = WAY_W'(w);
      end
    end
    if (!found_empty) begin
      for (int w = 0; w < WAYS; w++) begin
        if (st_q[lk_set][w] != ST_RSV && (!vic_ok || age_q[lk_set][w] > best_age)) begin
          vic_ok = 1'b1;
          vic_way = WAY_W'(w);
          best_age = age_q[lk_set][w];
        end
      end
    end
    vic_st  = st_q[lk_set][vic_way];
    vic_tag = tag_q[lk_set][vic_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= ST_EMPTY;
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (upd_en) begin
        st_q[lk_set][upd_way] <= upd_st;
        if (upd_tag) tag_q[lk_set][upd_way] <= lk_tag;
      end
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way) age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][touch_way])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
        end
      end
      if (fill_en) st_q[fill_set][fill_way] <= ST_CLEAN;
    end
  end

  // R3 R9: a tag is live in at most one way of a set
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);
endmodule

// File: rtl/dcache_mshr.sv
module dcache_mshr #(
  parameter int N         = 2,
  parameter int MERGE_MAX = 2,
  parameter int BLK_W     = 12,
  parameter int WAY_W     = 1,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 8,
  localparam int IDX_W = $clog2(N),
  localparam int MC_W  = $clog2(MERGE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  pr_blk,
  output logic              pr_hit,
  output logic              pr_full,
  output logic              free_ok,
  input  logic              merge_en,
  input  logic              alloc_en,
  input  logic [WAY_W-1:0]  alloc_way,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_blk,
  output logic              fill_hit,
  output logic [WAY_W-1:0]  fill_way,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [SIZE_W-1:0] rel_size
);
  logic [N-1:0]      vld, rdy;
  logic [BLK_W-1:0]  blk  [N];
  logic [WAY_W-1:0]  way  [N];
  logic [MC_W-1:0]   cnt  [N];
  logic [MC_W-1:0]   ridx [N];
  logic [ADDR_W-1:0] ra   [N][MERGE_MAX];
  logic [SIZE_W-1:0] rs   [N][MERGE_MAX];
  logic [IDX_W-1:0]  pr_idx, free_idx, fill_idx, rel_e;

  always_comb begin
    pr_hit = 1'b0; pr_idx = '0;
    free_ok = 1'b0; free_idx = '0;
    fill_hit = 1'b0; fill_idx = '0;
    rel_valid = 1'b0; rel_e = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && !rdy[i] && blk[i] == pr_blk) begin pr_hit = 1'b1; pr_idx = IDX_W'(i); end
      if (!vld[i]) begin free_ok = 1'b1; free_idx = IDX_W'(i); end
      if (vld[i] && !rdy[i] && blk[i] == fill_blk) begin fill_hit = 1'b1; fill_idx = IDX_W'(i); end
      if (rdy[i]) begin rel_valid = 1'b1; rel_e = IDX_W'(i); end
    end
    pr_full  = (cnt[pr_idx] == MC_W'(MERGE_MAX));
    fill_way = way[fill_idx];
    rel_addr = ra[rel_e][ridx[rel_e]];
    rel_size = rs[rel_e][ridx[rel_e]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rdy <= '0;
      for (int i = 0; i < N; i++) begin
        blk[i] <= '0; way[i] <= '0; cnt[i] <= '0; ridx[i] <= '0;
        for (int j = 0; j < MERGE_MAX; j++) begin ra[i][j] <= '0; rs[i][j] <= '0; end
      end
    end else begin
      if (alloc_en) begin
        vld[free_idx] <= 1'b1;
        rdy[free_idx] <= 1'b0;
        blk[free_idx] <= pr_blk;
        way[free_idx] <= alloc_way;
        cnt[free_idx] <= MC_W'(1);
        ridx[free_idx] <= '0;
        ra[free_idx][0] <= req_addr;
        rs[free_idx][0] <= req_size;
      end
      if (merge_en) begin
        ra[pr_idx][cnt[pr_idx]] <= req_addr;
        rs[pr_idx][cnt[pr_idx]] <= req_size;
        cnt[pr_idx] <= cnt[pr_idx] + 1'b1;
      end
      if (fill_en && fill_hit) rdy[fill_idx] <= 1'b1;
      if (rel_valid) begin
        if (ridx[rel_e] + 1'b1 == cnt[rel_e]) begin
          vld[rel_e] <= 1'b0;
          rdy[rel_e] <= 1'b0;
          ridx[rel_e] <= '0;
        end else begin
          ridx[rel_e] <= ridx[rel_e] + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lim
    a_r7_merge_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= MC_W'(MERGE_MAX));
  end

  a_r10_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_hit) |=> rel_valid);
endmodule

// File: rtl/dcache_mq.sv
module dcache_mq #(
  parameter int DEPTH = 4,
  parameter int W     = 26,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push0,
  input  logic [W-1:0]  d0,
  input  logic          push1,
  input  logic [W-1:0]  d1,
  input  logic          pop,
  output logic          head_vld,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    return PW'((int'(p) + n) % DEPTH);
  endfunction

  assign head_vld = (count != '0);
  assign head     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push0) mem[wp] <= d0;
      if (push1) mem[adv(wp, 1)] <= d1;
      wp <= adv(wp, int'(push0) + int'(push1));
      rp <= adv(rp, int'(pop));
      count <= CW'(int'(count) + int'(push0) + int'(push1) - int'(pop));
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  a_r6_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
    push1 |-> (int'(count) + 2 <= DEPTH));
  a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int MSHR_N     = 2,
  parameter int MERGE_MAX  = 2,
  parameter int MQ_DEPTH   = 4,
  parameter int SIZE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic [1:0]        resp_status,
  output logic              mq_valid,
  input  logic              mq_ready,
  output logic [1:0]        mq_kind,
  output logic [ADDR_W-1:0] mq_addr,
  output logic [SIZE_W-1:0] mq_size,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [SIZE_W-1:0] rel_size
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(MQ_DEPTH + 1);
  localparam int MQ_W  = 2 + ADDR_W + SIZE_W;
  localparam logic [SIZE_W-1:0] LINE_SZ = SIZE_W'(LINE_BYTES);

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [ADDR_W-1:0] base_of(input logic [BLK_W-1:0] b);
    return {b, {OFF_W{1'b0}}};
  endfunction

  logic [BLK_W-1:0] r_blk;
  logic             t_hit, v_ok;
  logic [WAY_W-1:0] t_hit_way, v_way;
  line_st_t         v_st;
  logic [TAG_W-1:0] v_tag;
  logic             m_hit, m_full, m_free, m_fill_hit;
  logic [WAY_W-1:0] m_fill_way;
  logic [CNT_W-1:0] mq_cnt;
  logic [MQ_W-1:0]  mq_head, d0, d1;
  logic             ok1, ok2, mq_pop;
  logic             upd_en, upd_tag, touch_en, push0, push1, merge_en, alloc_en;
  logic [WAY_W-1:0] upd_way, touch_way;
  line_st_t         upd_st;

  assign r_blk  = blk_of(req_addr);
  assign ok1    = int'(mq_cnt) < MQ_DEPTH;
  assign ok2    = int'(mq_cnt) + 1 < MQ_DEPTH;
  assign mq_pop = mq_valid && mq_ready;
  assign {mq_kind, mq_addr, mq_size} = mq_head;

  always_comb begin
    resp_status = RES_FAIL;
    upd_en = 1'b0; upd_tag = 1'b0; upd_way = t_hit_way; upd_st = ST_EMPTY;
    touch_en = 1'b0; touch_way = t_hit_way;
    push0 = 1'b0; push1 = 1'b0; merge_en = 1'b0; alloc_en = 1'b0;
    d0 = {MQ_WT, req_addr, req_size};
    d1 = {MQ_WB, base_of({v_tag, r_blk[SET_W-1:0]}), LINE_SZ};
    if (req_valid) begin
      if (t_hit) begin
        if (req_kind == ACC_GW) begin
          if (ok1) begin
            resp_status = RES_HIT;
            upd_en = 1'b1;
            push0 = 1'b1;
            d0 = {MQ_WB, base_of(r_blk), LINE_SZ};
          end
        end else begin
          resp_status = RES_HIT;
          touch_en = 1'b1;
          if (req_kind == ACC_LW) begin upd_en = 1'b1; upd_st = ST_DIRTY; end
        end
      end else if (req_kind != ACC_RD) begin
        if (ok1) begin resp_status = RES_MISS; push0 = 1'b1; end
      end else if (ok2) begin
        if (m_hit && !m_full) begin
          resp_status = RES_MISS;
          merge_en = 1'b1;
        end else if (!m_hit && m_free && v_ok) begin
          resp_status = RES_MISS;
          alloc_en = 1'b1;
          upd_en = 1'b1; upd_tag = 1'b1; upd_way = v_way; upd_st = ST_RSV;
          touch_en = 1'b1; touch_way = v_way;
          push0 = 1'b1;
          d0 = {MQ_FETCH, base_of(r_blk), LINE_SZ};
          push1 = (v_st == ST_DIRTY);
        end
      end
    end
  end

  dcache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n,
    .lk_set(r_blk[SET_W-1:0]), .lk_tag(r_blk[BLK_W-1:SET_W]),
    .hit(t_hit), .hit_way(t_hit_way),
    .vic_ok(v_ok), .vic_way(v_way), .vic_st(v_st), .vic_tag(v_tag),
    .upd_en, .upd_way, .upd_st, .upd_tag, .touch_en, .touch_way,
    .fill_en(fill_valid && m_fill_hit),
    .fill_set(fill_addr[OFF_W+SET_W-1:OFF_W]), .fill_way(m_fill_way)
  );

  dcache_mshr #(.N(MSHR_N), .MERGE_MAX(MERGE_MAX), .BLK_W(BLK_W), .WAY_W(WAY_W),
                .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_mshr (
    .clk, .rst_n,
    .pr_blk(r_blk), .pr_hit(m_hit), .pr_full(m_full), .free_ok(m_free),
    .merge_en, .alloc_en, .alloc_way(v_way), .req_addr, .req_size,
    .fill_en(fill_valid), .fill_blk(blk_of(fill_addr)),
    .fill_hit(m_fill_hit), .fill_way(m_fill_way),
    .rel_valid, .rel_addr, .rel_size
  );

  dcache_mq #(.DEPTH(MQ_DEPTH), .W(MQ_W)) u_mq (
    .clk, .rst_n, .push0, .d0, .push1, .d1, .pop(mq_pop),
    .head_vld(mq_valid), .head(mq_head), .count(mq_cnt)
  );

  // R6: a refused request never adds to the queue
  a_r6_fail_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == RES_FAIL) |=> mq_cnt <= $past(mq_cnt));
  // R2 R5: every miss that does not merge puts traffic in the queue
  a_r2_miss_enqueues: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_status == RES_MISS && !(req_kind == ACC_RD && m_hit) && !mq_pop)
      |=> mq_cnt > $past(mq_cnt));
endmodule

// File: tb/tb_dcache_ctrl.sv
`timescale 1ns/1ps
module tb_dcache_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_size = '0;
  logic [1:0]  resp_status;
  logic        mq_valid, mq_ready = 1'b0;
  logic [1:0]  mq_kind;
  logic [15:0] mq_addr;
  logic [7:0]  mq_size;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_addr = '0;
  logic        rel_valid;
  logic [15:0] rel_addr;
  logic [7:0]  rel_size;
  int checks = 0, errors = 0;

  localparam int HIT = 0, MISS = 1, FAIL = 2;
  localparam int RD = 0, LW = 1, GW = 2;
  localparam int FETCH = 0, WT = 1, WB = 2;

  always #2 clk = ~clk;

  dcache_ctrl dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 0; mq_ready = 0; fill_valid = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic access(input int kind, input int addr, input int size, input int exp, input string req);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_addr = 16'(addr); req_size = 8'(size);
    #1 chk(req, "status", int'(resp_status), exp);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic pop_expect(input int kind, input int addr, input int size, input string req);
    @(negedge clk);
    #1 chk(req, "mq_valid", int'(mq_valid), 1);
    chk(req, "mq_kind", int'(mq_kind), kind);
    chk(req, "mq_addr", int'(mq_addr), addr);
    chk(req, "mq_size", int'(mq_size), size);
    mq_ready = 1;
    @(posedge clk);
    #1 mq_ready = 0;
  endtask

  task automatic pop_any(input string req);
    @(negedge clk);
    #1 chk(req, "mq_valid", int'(mq_valid), 1);
    mq_ready = 1;
    @(posedge clk);
    #1 mq_ready = 0;
  endtask

  task automatic mq_empty(input string req);
    @(negedge clk);
    #1 chk(req, "mq_valid", int'(mq_valid), 0);
  endtask

  task automatic fill(input int addr);
    @(negedge clk);
    fill_valid = 1; fill_addr = 16'(addr);
    @(posedge clk);
    #1 fill_valid = 0;
  endtask

  task automatic rel_expect(input int addr, input int size, input string req);
    @(negedge clk);
    #1 chk(req, "rel_valid", int'(rel_valid), 1);
    chk(req, "rel_addr", int'(rel_addr), addr);
    chk(req, "rel_size", int'(rel_size), size);
  endtask

  task automatic rel_idle(input string req);
    @(negedge clk);
    #1 chk(req, "rel_valid", int'(rel_valid), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    mq_empty("R1");
    rel_idle("R1");
  endtask

  task automatic t_read_merge_fill();
    access(RD, 'h0104, 4, MISS, "R2");
    pop_expect(FETCH, 'h0100, 16, "R2");
    access(RD, 'h0108, 8, MISS, "R7");
    mq_empty("R7");
    access(RD, 'h010C, 4, FAIL, "R7");
    fill('h0100);
    rel_expect('h0104, 4, "R10");
    rel_expect('h0108, 8, "R10");
    rel_idle("R10");
    access(RD, 'h0100, 4, HIT, "R10");
    mq_empty("R2");
  endtask

  task automatic t_global_write_hit();
    access(GW, 'h0104, 4, HIT, "R3");
    pop_expect(WB, 'h0100, 16, "R3");
    access(RD, 'h0100, 4, MISS, "R3");
    pop_expect(FETCH, 'h0100, 16, "R3");
  endtask

  task automatic t_local_write_and_victims();
    do_reset();
    access(RD, 'h0200, 4, MISS, "R2");
    pop_any("R2");
    fill('h0200);
    rel_expect('h0200, 4, "R10");
    access(LW, 'h0204, 4, HIT, "R4");
    access(RD, 'h0400, 4, MISS, "R9");
    pop_expect(FETCH, 'h0400, 16, "R9");
    mq_empty("R9");
    fill('h0400);
    rel_expect('h0400, 4, "R10");
    access(RD, 'h0600, 4, MISS, "R9");
    pop_expect(FETCH, 'h0600, 16, "R9");
    pop_expect(WB, 'h0200, 16, "R4");
    access(RD, 'h0400, 4, HIT, "R9");
  endtask

  task automatic t_write_miss_and_limits();
    do_reset();
    access(LW, 'h0300, 4, MISS, "R5");
    access(GW, 'h0310, 4, MISS, "R5");
    access(RD, 'h0300, 4, MISS, "R5");
    access(RD, 'h0500, 4, FAIL, "R6");
    access(LW, 'h0700, 4, MISS, "R5");
    access(LW, 'h0800, 4, FAIL, "R5");
    pop_expect(WT, 'h0300, 4, "R11");
    pop_expect(WT, 'h0310, 4, "R11");
    pop_expect(FETCH, 'h0300, 16, "R11");
    pop_expect(WT, 'h0700, 4, "R11");
    mq_empty("R11");
  endtask

  task automatic t_global_write_full();
    do_reset();
    access(RD, 'h0100, 4, MISS, "R2");
    pop_any("R2");
    fill('h0100);
    rel_expect('h0100, 4, "R10");
    for (int i = 0; i < 4; i++) access(LW, 'h0900 + 16 * i, 4, MISS, "R5");
    access(GW, 'h0104, 4, FAIL, "R3");
    pop_any("R3");
    access(GW, 'h0104, 4, HIT, "R3");
    for (int i = 0; i < 3; i++) pop_any("R3");
    pop_expect(WB, 'h0100, 16, "R3");
  endtask

  task automatic t_mshr_exhaust();
    do_reset();
    access(RD, 'h0000, 4, MISS, "R8");
    pop_any("R8");
    access(RD, 'h0010, 4, MISS, "R8");
    pop_any("R8");
    access(RD, 'h0020, 4, FAIL, "R8");
    mq_empty("R8");
    fill('h0000);
    rel_expect('h0000, 4, "R10");
    access(RD, 'h0020, 4, MISS, "R8");
  endtask

  initial begin
    t_reset_state();
    t_read_merge_fill();
    t_global_write_hit();
    t_local_write_and_victims();
    t_write_miss_and_limits();
    t_global_write_full();
    t_mshr_exhaust();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule